// File: doc/BRIEF.md
# Serial Synthesizer Configuration Loader

This block sits in the FPGA fabric and programs an external frequency synthesizer through a three-wire serial link. The link has a serial clock, a data line and a latch enable. A start request makes the block send a fixed list of 32-bit configuration words. The word values come from a parameter table. Each word goes out most significant bit first. After the last bit of a word, one clean latch-enable pulse commits that word.

The final word in the list (address 0) makes the synthesizer begin calibrating its VCO. That calibration only gives a correct result if the reference clock is already running. For this reason the block holds back the final word until the reference-valid input is high. The words before it are sent without waiting for that input. The block reports busy while a load runs and gives a single-cycle done pulse once the final word has been latched. Between words and while idle, latch enable stays low and the serial clock stays quiet.

The serial clock comes from the system clock. Each half period of the serial clock lasts `HALF_DIV` system cycles, so a 125 MHz system clock and `HALF_DIV` = 10 give about 6.25 MHz.

Top module: `synthCfgLoader`

## Requirements
- R1: After reset, serClk, serData, latchEn, busy and done are all low.
- R2: Each load sends all NUM_WORDS table entries. Entry 0 goes first and entry NUM_WORDS-1 goes last. Bits [3:0] of each word hold its register address. With the default table the address order is 7, 13, 12, 9, 8, 6, 5, 4, 3, 2, 1, 0, so address 0 always comes last.
- R3: Each word gives exactly WORD_W rising serClk edges, MSB first. serData changes only while serClk is low, and it holds steady for the whole time serClk is high.
- R4: Within a word, consecutive rising serClk edges are exactly 2*HALF_DIV system cycles apart.
- R5: latchEn rises only after all WORD_W bits of a word have been clocked in, and it rises exactly once per word. serClk stays low while latchEn is high. latchEn stays low while the block is idle.
- R6: Each latchEn pulse is high for exactly 2*HALF_DIV system cycles. After latchEn falls, at least 2*HALF_DIV cycles pass before the next word's first rising serClk edge.
- R7: While refValid is low, the block sends no part of the final word, and busy stays high. Once refValid is high, the final word goes out. The earlier words are not gated by refValid.
- R8: busy is high in the cycle after an accepted start. done is a one-cycle pulse 2*HALF_DIV cycles after the final latchEn falls. busy is already low in the cycle where done is high.
- R9: A startReq that arrives while busy is ignored. The load in progress carries on, and it sends exactly NUM_WORDS words and one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin a load (ignored while busy) |
| refValid | input | 1 | Reference clock present and valid; gates the final word |
| serClk | output | 1 | Serial clock to the synthesizer |
| serData | output | 1 | Serial data, MSB first |
| latchEn | output | 1 | Commits the word just shifted; low when not committing |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse after the final word is latched |

## Verification
Every result has a fixed cycle offset from its stimulus:
- busy is checked one cycle after startReq is driven.
- Each rising serClk edge is due 2*HALF_DIV cycles after the one before it.
- latchEn must fall exactly 2*HALF_DIV cycles after it rose.
- done is due exactly 2*HALF_DIV cycles after the final latchEn falls.

A monitor samples all outputs on the falling system-clock edge and timestamps each serClk and latchEn transition with a cycle counter. The checks compare those time differences against the arithmetic values from the small bench divider. Captured words are compared against the bench's own copy of the table and its own list of address nibbles. The refValid gating check waits until exactly eleven words have landed, then holds for many serial periods to confirm that nothing more moves.

// File: rtl/synthCfgPkg.sv
package synthCfgPkg;

  // Strobes from the sequencer to the serial datapath
  typedef struct packed {
    logic loadWord;   // capture the selected word and start shifting
    logic latchSet;   // raise latch enable
    logic latchClr;   // drop latch enable
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SHIFT,
    ST_LATCH,
    ST_GAP
  } ctrlState_e;

endpackage

// File: rtl/cfgSerialPath.sv
module cfgSerialPath
  import synthCfgPkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int HALF_DIV = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [WORD_W-1:0] wordIn,
  output logic              tick,
  output logic              shDone,
  output logic              serClk,
  output logic              serData,
  output logic              latchEn
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(WORD_W - 1);

  logic [DIV_W-1:0]  divCnt;
  logic [WORD_W-1:0] shReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              shActive;
  logic              clkQ;
  logic              leQ;

  // Half-period divider, realigned whenever a new word is loaded
  always_ff @(posedge clk) begin
    if (!rstN || strb.loadWord || divCnt == DIV_LAST) divCnt <= '0;
    else                                              divCnt <= divCnt + DIV_W'(1);
  end

  assign tick   = (divCnt == DIV_LAST);
  assign shDone = shActive && tick && clkQ && (bitCnt == BIT_LAST);

  // Bit engine: rise on one tick, fall and advance on the next
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      bitCnt   <= '0;
      shActive <= 1'b0;
      clkQ     <= 1'b0;
    end else if (strb.loadWord) begin
      shReg    <= wordIn;
      bitCnt   <= '0;
      shActive <= 1'b1;
      clkQ     <= 1'b0;
    end else if (shActive && tick) begin
      if (!clkQ) begin
        clkQ <= 1'b1;
      end else begin
        clkQ   <= 1'b0;
        shReg  <= {shReg[WORD_W-2:0], 1'b0};
        bitCnt <= bitCnt + CNT_W'(1);
        if (bitCnt == BIT_LAST) shActive <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              leQ <= 1'b0;
    else if (strb.latchSet) leQ <= 1'b1;
    else if (strb.latchClr) leQ <= 1'b0;
  end

  assign serClk  = clkQ;
  assign serData = shReg[WORD_W-1];
  assign latchEn = leQ;

  a_r5_clk_low_while_latch: assert property (@(posedge clk) disable iff (!rstN)
    leQ |-> !clkQ);

  a_r5_latch_after_word: assert property (@(posedge clk) disable iff (!rstN)
    $rose(leQ) |-> !shActive);

  a_r3_data_held_high: assert property (@(posedge clk) disable iff (!rstN)
    clkQ |-> $stable(shReg[WORD_W-1]));

  a_r4_edge_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (clkQ != $past(clkQ)) |-> $past(tick));

endmodule

// File: rtl/cfgSeqCtrl.sv
module cfgSeqCtrl
  import synthCfgPkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 12,
  parameter logic [NUM_WORDS*WORD_W-1:0] CFG_WORDS = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              refValid,
  input  logic              tick,
  input  logic              shDone,
  output dpStrobe_t         strb,
  output logic [WORD_W-1:0] wordOut,
  output logic              busy,
  output logic              done
);

  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_WORDS - 1);

  ctrlState_e       state;
  logic [IDX_W-1:0] wordIdx;
  logic             phase;
  logic             lastIdx;

  assign lastIdx = (wordIdx == IDX_LAST);
  assign wordOut = CFG_WORDS[int'(wordIdx)*WORD_W +: WORD_W];
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strb = '0;
    case (state)
      ST_ARM:   strb.loadWord = !lastIdx || refValid;  // final word waits for reference
      ST_SHIFT: strb.latchSet = shDone;
      ST_LATCH: strb.latchClr = tick && phase;
      default:  strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
      phase   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state   <= ST_ARM;
            wordIdx <= '0;
          end
        end
        ST_ARM: begin
          if (strb.loadWord) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (shDone) begin
            state <= ST_LATCH;
            phase <= 1'b0;
          end
        end
        ST_LATCH: begin
          if (tick) begin
            phase <= !phase;
            if (phase) state <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) begin
            phase <= !phase;
            if (phase) begin
              if (lastIdx) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end else begin
                wordIdx <= wordIdx + IDX_W'(1);
                state   <= ST_ARM;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r7_hold_final_word: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARM && lastIdx && !refValid) |=> (state == ST_ARM));

  a_r8_done_while_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && state != ST_GAP) |=> $stable(wordIdx));

endmodule

// File: rtl/synthCfgLoader.sv
module synthCfgLoader
  import synthCfgPkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 12,
  parameter int HALF_DIV  = 10,
  parameter logic [NUM_WORDS*WORD_W-1:0] CFG_WORDS = {
    32'h0000_2A10, 32'h0000_0191, 32'h0500_00F2, 32'h0E40_8103,
    32'h9100_4C54, 32'hB000_0015, 32'h003E_6626, 32'h0222_D018,
    32'h1F00_2A39, 32'h0000_004C, 32'h0000_120D, 32'h00A5_3C07 }
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic refValid,
  output logic serClk,
  output logic serData,
  output logic latchEn,
  output logic busy,
  output logic done
);

  dpStrobe_t         strb;
  logic [WORD_W-1:0] curWord;
  logic              tick;
  logic              shDone;

  cfgSeqCtrl #(
    .WORD_W   (WORD_W),
    .NUM_WORDS(NUM_WORDS),
    .CFG_WORDS(CFG_WORDS)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .refValid(refValid),
    .tick    (tick),
    .shDone  (shDone),
    .strb    (strb),
    .wordOut (curWord),
    .busy    (busy),
    .done    (done)
  );

  cfgSerialPath #(
    .WORD_W  (WORD_W),
    .HALF_DIV(HALF_DIV)
  ) path_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wordIn (curWord),
    .tick   (tick),
    .shDone (shDone),
    .serClk (serClk),
    .serData(serData),
    .latchEn(latchEn)
  );

endmodule

// File: tb/synthCfgLoader_tb_top.sv
`timescale 1ns/1ps
module synthCfgLoader_tb_top;

  localparam int H   = 3;
  localparam int NW  = 12;
  localparam int W   = 32;
  localparam int PER = 2 * H;

  localparam logic [31:0] EXP [NW] = '{
    32'h00A5_3C07, 32'h0000_120D, 32'h0000_004C, 32'h1F00_2A39,
    32'h0222_D018, 32'h003E_6626, 32'hB000_0015, 32'h9100_4C54,
    32'h0E40_8103, 32'h0500_00F2, 32'h0000_0191, 32'h0000_2A10 };
  localparam int EXP_ADDR [NW] = '{7, 13, 12, 9, 8, 6, 5, 4, 3, 2, 1, 0};

  function automatic logic [NW*W-1:0] packTable();
    logic [NW*W-1:0] t;
    for (int k = 0; k < NW; k++) t[k*W +: W] = EXP[k];
    return t;
  endfunction

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic refValid = 1'b0;
  logic serClk, serData, latchEn, busy, done;

  always #4 clk = ~clk;

  synthCfgLoader #(
    .WORD_W(W), .NUM_WORDS(NW), .HALF_DIV(H), .CFG_WORDS(packTable())
  ) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .refValid(refValid),
    .serClk(serClk), .serData(serData), .latchEn(latchEn),
    .busy(busy), .done(done)
  );

  // ---------------- monitor ----------------
  int monChecks = 0, monFails = 0;
  longint cyc = 0;
  logic prevClk = 1'b0, prevLe = 1'b0, prevData = 1'b0;
  logic [31:0] shiftIn = '0;
  int bitsIn = 0;
  int wordCount = 0;
  int doneCount = 0;
  logic [31:0] capWords [64];
  longint lastRise = 0, leRise = 0, leFall = -1000;

  task automatic monCheck(input logic ok, input string tag, input longint act, input longint exp);
    monChecks++;
    if (!ok) begin
      monFails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (serClk && !prevClk) begin
        if (bitsIn > 0) monCheck((cyc - lastRise) == PER, "R4 serial period", cyc - lastRise, PER);
        else if (wordCount > 0) monCheck((cyc - leFall) >= PER, "R6 gap before word", cyc - leFall, PER);
        lastRise <= cyc;
        shiftIn  <= {shiftIn[30:0], serData};
        bitsIn   <= bitsIn + 1;
      end
      if (serClk && prevClk)
        monCheck(serData == prevData, "R3 data stable while clock high", serData, prevData);
      if (serClk && latchEn)
        monCheck(1'b0, "R5 clock high during latch", 1, 0);
      if (latchEn && !prevLe) begin
        monCheck(bitsIn == W, "R5 bits before latch", bitsIn, W);
        monCheck(busy, "R5 latch only while busy", busy, 1);
        if (wordCount < 64) capWords[wordCount] <= shiftIn;
        wordCount <= wordCount + 1;
        bitsIn    <= 0;
        leRise    <= cyc;
      end
      if (!latchEn && prevLe) begin
        monCheck((cyc - leRise) == PER, "R6 latch width", cyc - leRise, PER);
        leFall <= cyc;
      end
      if (done) begin
        monCheck((cyc - leFall) == PER, "R8 done after last latch", cyc - leFall, PER);
        monCheck(!busy, "R8 busy low with done", busy, 0);
        doneCount <= doneCount + 1;
      end
    end
    prevClk  <= serClk;
    prevLe   <= latchEn;
    prevData <= serData;
  end

  // ---------------- stimulus ----------------
  int mainChecks = 0, mainFails = 0;
  logic finished = 1'b0;

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    mainChecks++;
    if (!ok) begin
      mainFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  task automatic waitDone(input int base);
    int guard = 0;
    while (doneCount == base && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic checkLoad(input int base, input string tag);
    for (int k = 0; k < NW; k++) begin
      check(capWords[base + k] == EXP[k], tag, capWords[base + k], EXP[k]);
      check(int'(capWords[base + k][3:0]) == EXP_ADDR[k], "R2 address order",
            capWords[base + k][3:0], EXP_ADDR[k]);
    end
  endtask

  initial begin
    int wBase, dBase;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(!serClk && !serData && !latchEn, "R1 serial pins low", {serClk, serData, latchEn}, 0);
    check(!busy && !done, "R1 status low", {busy, done}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!serClk && !latchEn && !busy, "R1 idle after reset", {serClk, latchEn, busy}, 0);

    // Load with reference present
    refValid = 1'b1;
    wBase = wordCount; dBase = doneCount;
    pulseStart();
    check(busy, "R8 busy after start", busy, 1);
    waitDone(dBase);
    check(doneCount == dBase + 1, "R8 one done", doneCount - dBase, 1);
    check(wordCount == wBase + NW, "R2 word count", wordCount - wBase, NW);
    checkLoad(wBase, "R2 word value");

    // Reference missing: final word withheld
    refValid = 1'b0;
    wBase = wordCount; dBase = doneCount;
    pulseStart();
    while (wordCount < wBase + NW - 1) @(negedge clk);
    repeat (20 * PER) @(negedge clk);
    pulseStart();  // R9 start while busy
    repeat (10 * PER) @(negedge clk);
    check(wordCount == wBase + NW - 1, "R7 final word held", wordCount - wBase, NW - 1);
    check(busy, "R7 busy while waiting", busy, 1);
    check(!serClk && !latchEn, "R7 link quiet while waiting", {serClk, latchEn}, 0);
    check(doneCount == dBase, "R7 no done yet", doneCount - dBase, 0);
    refValid = 1'b1;
    waitDone(dBase);
    check(wordCount == wBase + NW, "R7 final word sent", wordCount - wBase, NW);
    checkLoad(wBase, "R7 word value");

    // Repeated start requests mid-load
    wBase = wordCount; dBase = doneCount;
    pulseStart();
    repeat (5 * W * PER) @(negedge clk);
    pulseStart();
    repeat (3 * W * PER) @(negedge clk);
    pulseStart();
    waitDone(dBase);
    check(doneCount == dBase + 1, "R9 single done", doneCount - dBase, 1);
    check(wordCount == wBase + NW, "R9 word count", wordCount - wBase, NW);
    checkLoad(wBase, "R9 word value");

    // Idle quietness
    wBase = wordCount;
    repeat (50 * PER) @(negedge clk);
    check(wordCount == wBase && !latchEn && !serClk, "R5 idle quiet", wordCount - wBase, 0);
    check(!busy, "R8 idle after done", busy, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             mainChecks + monChecks, mainFails + monFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***",
               mainChecks + monChecks + 1, mainFails + monFails + 1);
      $finish;
    end
  end

endmodule